// File: doc/BRIEF.md
# Symbol Timing Delay Tracker

This block sits in a receive chain that runs at M samples per symbol. It turns the filtered timing error into a whole-sample delay. It then applies that delay to the incoming sample stream.

A phase counter marks the symbol boundary. Once per symbol, at phase 0, the current error word is added to a signed accumulator. When the accumulator reaches one full sample step, it wraps by that step and keeps the remainder. The wrap also emits a single increment or decrement request for the delay.

The delay is held in a register that saturates at both ends of the delay line. Its value selects the tap of a shift register that carries the received samples. The error input is signed fixed point with FRAC_W fractional bits, so one whole sample equals 2^FRAC_W. Its magnitude stays below one sample.

Top module: `timing_delay_tracker`

## Requirements
- R1: `phase` is 0 after reset and advances by one on every clock edge. After M-1 it returns to 0.
- R2: While reset is asserted, `delay` equals INIT_DLY, `phase` is 0, `step_up` and `step_dn` are 0, the accumulator is 0 and every delay-line stage is 0.
- R3: On an edge where `phase` is 0, the sum S = accumulator + `err_i` is formed.
  - If S >= 2^FRAC_W, the accumulator becomes S - 2^FRAC_W and `step_dn` is 1 for the following cycle.
  - If S <= -2^FRAC_W, the accumulator becomes S + 2^FRAC_W and `step_up` is 1 for the following cycle.
  - Otherwise the accumulator becomes S and neither pulse is set.
  - The two pulses are never high together.
- R4: `err_i` has no effect on any edge where `phase` is not 0. No pulse is set and `delay` does not change.
- R5: `delay` changes only on an edge where `phase` is 0. On a `step_dn` event it decreases by one, so a positive (late) error shortens the delay. On a `step_up` event it increases by one, so a negative (early) error lengthens it.
- R6: `delay` saturates at 0 and at DEPTH-1. A step beyond either limit leaves it unchanged, but the pulse is still emitted.
- R7: A fractional remainder left after a wrap carries into the next symbol rather than being cleared.
- R8: With `err_i` held at 0, `delay` stays constant and no pulse occurs.
- R9: `dout` equals the `din` value captured delay+1 clock edges earlier. A new `delay` value selects its tap from the first cycle in which it is visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, M times the symbol rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_i | input | FRAC_W+1 | Signed filtered timing error |
| din | input | DW | Received sample |
| dout | output | DW | Delayed sample |
| delay | output | clog2(DEPTH) | Current tap index |
| phase | output | clog2(M) | Symbol phase counter |
| step_up | output | 1 | Delay-increment event, one cycle |
| step_dn | output | 1 | Delay-decrement event, one cycle |

## Verification
The tracker is exercised with the following error patterns, and each separates a different fault:
- A zero error shows that nothing drifts.
- Steady positive and negative fractions that do not divide a whole step show the wrap direction and its cadence.
- A repeated 48/64 pattern produces a second step only if the remainder survives. It therefore separates residue carry from clearing.
- Long runs of near-full errors drive the delay into both rails, which shows the saturation and the pulses that persist there.
- Large errors placed on non-zero phases confirm that they are ignored.

The delay line is checked on every cycle against a running history of a stepping input ramp. This covers the cycles immediately after each tap change.

// File: rtl/timing_delay_tracker.sv
module timing_delay_tracker #(
  parameter int DW       = 8,
  parameter int M        = 4,
  parameter int DEPTH    = 8,
  parameter int FRAC_W   = 6,
  parameter int INIT_DLY = 4,
  localparam int PW = (M > 1) ? $clog2(M) : 1,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int EW = FRAC_W + 1,
  localparam int SW = FRAC_W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [EW-1:0] err_i,
  input  logic        [DW-1:0] din,
  output logic        [DW-1:0] dout,
  output logic        [AW-1:0] delay,
  output logic        [PW-1:0] phase,
  output logic                 step_up,
  output logic                 step_dn
);

  localparam logic signed [SW-1:0] STEP = SW'(1 << FRAC_W);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  logic signed [SW-1:0] acc, sum;
  logic                 at_sym, over, under;
  logic [DW-1:0]        sr [DEPTH];

  assign at_sym = (phase == '0);
  assign sum    = acc + {err_i[EW-1], err_i};
  assign over   = sum >= STEP;
  assign under  = sum <= -STEP;
  assign dout   = sr[delay];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   phase <= '0;
    else if (phase == PW'(M - 1)) phase <= '0;
    else                          phase <= phase + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      delay   <= AW'(INIT_DLY);
      step_up <= 1'b0;
      step_dn <= 1'b0;
    end else begin
      step_up <= 1'b0;
      step_dn <= 1'b0;
      if (at_sym) begin
        if (over) begin
          acc     <= sum - STEP;
          step_dn <= 1'b1;
          if (delay != '0) delay <= delay - AW'(1);
        end else if (under) begin
          acc     <= sum + STEP;
          step_up <= 1'b1;
          if (delay != TOP) delay <= delay + AW'(1);
        end else begin
          acc <= sum;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
    end else begin
      sr[0] <= din;
      for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
    end
  end

endmodule

module timing_delay_tracker_chk #(
  parameter int M     = 4,
  parameter int DEPTH = 8,
  parameter int PW    = 2,
  parameter int AW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [PW-1:0] phase,
  input logic [AW-1:0] delay,
  input logic          step_up,
  input logic          step_dn
);

  assert_phase_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PW'(M - 1)) |=> (phase == '0));

  assert_phase_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PW'(M - 1)) |=> (phase == $past(phase) + PW'(1)));

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up && step_dn));

  assert_pulse_after_symbol_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up || step_dn) |-> (phase == PW'(1 % M)));

  assert_hold_off_symbol_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != '0) |=> $stable(delay));

  assert_delay_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    delay <= AW'(DEPTH - 1));

  assert_move_needs_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_up && !step_dn) |-> (delay == $past(delay)));

endmodule

bind timing_delay_tracker timing_delay_tracker_chk #(
  .M(M), .DEPTH(DEPTH), .PW(PW), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .delay(delay),
  .step_up(step_up), .step_dn(step_dn)
);

// File: tb/timing_delay_tracker_tb.sv
module timing_delay_tracker_tb;
  localparam int DW = 8, M = 4, DEPTH = 8, FRAC_W = 6, INIT_DLY = 4;
  localparam int STEP = 1 << FRAC_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [FRAC_W:0] err_i = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic [2:0] delay;
  logic [1:0] phase;
  logic step_up, step_dn;

  int total = 0, bad = 0;
  int acc_m = 0, dly_m = INIT_DLY;
  logic [DW-1:0] hist [DEPTH];

  always #2 clk = ~clk;

  timing_delay_tracker #(.DW(DW), .M(M), .DEPTH(DEPTH), .FRAC_W(FRAC_W),
    .INIT_DLY(INIT_DLY)) u_dut (
    .clk(clk), .rst_n(rst_n), .err_i(err_i), .din(din), .dout(dout),
    .delay(delay), .phase(phase), .step_up(step_up), .step_dn(step_dn));

  always @(posedge clk) begin
    if (!rst_n) for (int i = 0; i < DEPTH; i++) hist[i] = '0;
    else begin
      for (int i = DEPTH - 1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = din;
    end
  end

  always @(negedge clk) if (rst_n) din <= din + 8'd37;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_dout();
    chk(dout == hist[dly_m], "R9 dout tap", dout, hist[dly_m]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    err_i = '0;
    din = '0;
    acc_m = 0;
    dly_m = INIT_DLY;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Phase is 0 at the negedge on entry; one full symbol is run and checked.
  task automatic sym(input int e, input int junk);
    int s;
    bit up, dn;
    err_i = e[FRAC_W:0];
    s = acc_m + e;
    up = 0;
    dn = 0;
    if (s >= STEP) begin
      acc_m = s - STEP;
      dn = 1;
      if (dly_m > 0) dly_m--;
    end else if (s <= -STEP) begin
      acc_m = s + STEP;
      up = 1;
      if (dly_m < DEPTH - 1) dly_m++;
    end else acc_m = s;
    @(negedge clk);
    chk(step_dn == dn, "R3 step_dn", step_dn, dn);
    chk(step_up == up, "R3 step_up", step_up, up);
    chk(delay == dly_m, "R5 delay update", delay, dly_m);
    chk_dout();
    err_i = junk[FRAC_W:0];
    for (int k = 1; k < M; k++) begin
      if (k > 1) begin
        chk(!step_up && !step_dn, "R4 no pulse off symbol", {step_up, step_dn}, 0);
        chk(delay == dly_m, "R4 delay held", delay, dly_m);
        chk_dout();
      end
      @(negedge clk);
    end
    chk(phase == 0, "R1 phase realign", phase, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(delay == INIT_DLY, "R2 delay init", delay, INIT_DLY);
    chk(phase == 0, "R2 phase zero", phase, 0);
    chk(!step_up && !step_dn, "R2 pulses low", {step_up, step_dn}, 0);
    chk(dout == 0, "R2 line clear", dout, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_phase();
    for (int k = 0; k < 2 * M; k++) begin
      chk(phase == (k % M), "R1 phase count", phase, k % M);
      @(negedge clk);
    end
  endtask

  task automatic t_zero();
    for (int k = 0; k < 4; k++) sym(0, 0);
    chk(delay == INIT_DLY, "R8 zero error hold", delay, INIT_DLY);
  endtask

  task automatic t_late();
    for (int k = 0; k < 5; k++) sym(40, -60);
  endtask

  task automatic t_early();
    for (int k = 0; k < 7; k++) sym(-50, 63);
  endtask

  task automatic t_residue();
    do_reset();
    sym(48, 0);
    chk(!step_dn, "R7 first no step", step_dn, 0);
    sym(48, 0);
    sym(32, 0);
    chk(delay == INIT_DLY - 2, "R7 residue carried", delay, INIT_DLY - 2);
  endtask

  task automatic t_sat_low();
    for (int k = 0; k < DEPTH + 3; k++) sym(63, 0);
    chk(delay == 0, "R6 floor", delay, 0);
  endtask

  task automatic t_sat_high();
    for (int k = 0; k < 2 * DEPTH + 4; k++) sym(-63, 0);
    chk(delay == DEPTH - 1, "R6 ceiling", delay, DEPTH - 1);
  endtask

  bit finished = 0;

  initial begin
    #200000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_phase();
    t_zero();
    t_late();
    t_early();
    t_residue();
    t_sat_low();
    t_sat_high();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule